// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations in a small fully associative array. Every lookup compares the incoming virtual page number against all stored entries at once. A hit returns the physical address and the attribute bits stored with the entry. Each entry is tagged with an address-space identifier and a virtual-machine identifier, so a context switch or a guest switch leaves the contents in place. An entry marked global serves every address space. A miss only raises a flag; fetching the missing translation belongs to the surrounding logic, which then writes it through the fill port.

Each entry records its own page granule (4, 16 or 64 KB). The page-offset bits of that granule take no part in the tag compare and pass unchanged from the virtual to the physical address. Two runtime bits select 8-bit or 16-bit comparison of the address-space and machine identifiers. A physical-size input limits the width of the returned address to at most 40 bits. Three invalidate forms remove entries in a single cycle: all entries, entries of one address space, or entries of one virtual machine.

Top module: `vtlb_fa`

## Requirements
- R1: The array holds 48 entries and any entry may hold any page. A fill writes the lowest-indexed invalid entry when one exists, and the new entry is valid from the next cycle.
- R2: When all 48 entries are valid, a fill replaces the entry selected by a round-robin pointer. The pointer resets to 0 and advances by one, wrapping after 47, on every fill cycle.
- R3: A global entry matches whatever the current address-space ID is. A non-global entry matches only when its stored address-space ID equals the current one.
- R4: An entry matches only when its stored machine ID equals the current machine ID.
- R5: With `asid16_i` = 0 only bits [7:0] of the stored and current address-space IDs are compared; with 1 all 16 bits are compared. The same width applies to invalidate-by-address-space.
- R6: With `vmid16_i` = 0 only bits [7:0] of the stored and current machine IDs are compared; with 1 all 16 bits are compared. The same width applies to both ID-based invalidates.
- R7: `fill_gran_i` encodes the granule as 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = 4 KB. Virtual address bits below 12, 14 or 16 respectively are left out of the tag compare and are copied into the physical address at the same positions.
- R8: `pa_bits_i` gives the physical address width; any value above 40 acts as 40. Physical address bits at and above the effective width are returned as zero.
- R9: A lookup presented in one cycle gives `rsp_valid_o` and either `hit_o` or `miss_o` after the next clock edge. On a hit `pa_o` and `attr_o` come from the lowest-indexed matching entry, and `multi_hit_o` is 1 when more than one entry matched. After reset all outputs are 0.
- R10: `inv_kind_i` = 0 clears every entry in one cycle. The value 3 has no effect.
- R11: `inv_kind_i` = 1 clears each non-global entry whose address-space ID and machine ID both equal the invalidate IDs. Global entries are kept.
- R12: `inv_kind_i` = 2 clears every entry, global or not, whose machine ID equals the invalidate machine ID.
- R13: A lookup in the same cycle as a fill of the same page sees the array as it was before the fill, so it misses.
- R14: When a fill and an invalidate occur in the same cycle, the invalidate acts on the old contents and the filled entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid16_i | input | 1 | 1 = compare 16-bit address-space IDs, 0 = low 8 bits |
| vmid16_i | input | 1 | 1 = compare 16-bit machine IDs, 0 = low 8 bits |
| pa_bits_i | input | 7 | Requested physical address width, clamped to 40 |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 48 | Lookup virtual address |
| lk_asid_i | input | 16 | Current address-space ID |
| lk_vmid_i | input | 16 | Current machine ID |
| fill_i | input | 1 | Write a new entry |
| fill_va_i | input | 48 | Virtual address of the new page |
| fill_pa_i | input | 40 | Physical address of the new page |
| fill_gran_i | input | 2 | Granule of the new page |
| fill_global_i | input | 1 | New entry is global |
| fill_asid_i | input | 16 | Address-space ID of the new entry |
| fill_vmid_i | input | 16 | Machine ID of the new entry |
| fill_attr_i | input | 8 | Attribute bits of the new entry |
| inv_i | input | 1 | Invalidate request |
| inv_kind_i | input | 2 | 0 all, 1 by address space, 2 by machine, 3 none |
| inv_asid_i | input | 16 | Address-space ID for invalidate |
| inv_vmid_i | input | 16 | Machine ID for invalidate |
| rsp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| multi_hit_o | output | 1 | More than one entry matched |
| pa_o | output | 40 | Translated physical address |
| attr_o | output | 8 | Attribute bits of the hit entry |

## Verification
A lookup result is due one clock edge after the cycle in which the request is presented. Fills and invalidates change the array at the edge that ends their cycle, so they show up in a lookup presented in the following cycle. The bench drives every input on the falling edge and holds it for one rising edge. It samples the registered result at the next falling edge, before any other input changes. For the same-cycle case the lookup and the fill share one cycle, and the bench checks that the result taken at that falling edge is a miss. A lookup in the next cycle must then hit.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int unsigned ID_W     = 16;
  localparam int unsigned PG_SHIFT = 12;

  typedef enum logic [1:0] {
    GRAN_4K  = 2'd0,
    GRAN_16K = 2'd1,
    GRAN_64K = 2'd2,
    GRAN_ALT = 2'd3
  } gran_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_VMID = 2'd2,
    INV_NOP  = 2'd3
  } inv_e;

  function automatic logic id_eq(logic [ID_W-1:0] a, logic [ID_W-1:0] b, logic wide);
    return wide ? (a == b) : (a[7:0] == b[7:0]);
  endfunction

  // number of low page-number bits dropped from the tag for a granule
  function automatic logic [2:0] gran_ign(logic [1:0] g);
    case (g)
      GRAN_16K: return 3'd2;
      GRAN_64K: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
  import vtlb_pkg::*;
#(
  parameter int unsigned VPN_W = 36
) (
  input  logic             e_valid_i,
  input  logic [VPN_W-1:0] e_vpn_i,
  input  logic [1:0]       e_gran_i,
  input  logic             e_glob_i,
  input  logic [ID_W-1:0]  e_asid_i,
  input  logic [ID_W-1:0]  e_vmid_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [ID_W-1:0]  asid_i,
  input  logic [ID_W-1:0]  vmid_i,
  input  logic             asid16_i,
  input  logic             vmid16_i,
  output logic             hit_o
);
  logic [VPN_W-1:0] cmp_mask;
  logic             tag_eq;

  always_comb begin
    cmp_mask = {VPN_W{1'b1}} << gran_ign(e_gran_i);
    tag_eq   = ((e_vpn_i ^ vpn_i) & cmp_mask) == '0;
    hit_o    = e_valid_i && tag_eq
            && (e_glob_i || id_eq(e_asid_i, asid_i, asid16_i))
            && id_eq(e_vmid_i, vmid_i, vmid16_i);
  end
endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick #(
  parameter int unsigned N     = 48,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o,
  output logic             multi_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !any_o) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
    multi_o = |(req_i & (req_i - N'(1)));
  end
endmodule

// File: rtl/vtlb_victim.sv
module vtlb_victim #(
  parameter int unsigned N     = 48,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             fill_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] free_idx, rr_q;
  logic             free_any, unused_multi;

  vtlb_pick #(.N(N), .IDX_W(IDX_W)) u_free (
    .req_i  (~valid_i),
    .idx_o  (free_idx),
    .any_o  (free_any),
    .multi_o(unused_multi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rr_q <= '0;
    else if (fill_i) rr_q <= (rr_q == IDX_W'(N-1)) ? '0 : rr_q + 1'b1;
  end

  assign idx_o = free_any ? free_idx : rr_q;

  assert_rr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rr_q) < int'(N));
  assert_rr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> rr_q == $past(rr_q));
endmodule

// File: rtl/vtlb_fa.sv
module vtlb_fa
  import vtlb_pkg::*;
#(
  parameter int unsigned N_ENT  = 48,
  parameter int unsigned VA_W   = 48,
  parameter int unsigned PA_MAX = 40,
  parameter int unsigned ATTR_W = 8,
  localparam int unsigned PSZ_W = $clog2(PA_MAX + 1) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asid16_i,
  input  logic              vmid16_i,
  input  logic [PSZ_W-1:0]  pa_bits_i,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ID_W-1:0]   lk_asid_i,
  input  logic [ID_W-1:0]   lk_vmid_i,
  input  logic              fill_i,
  input  logic [VA_W-1:0]   fill_va_i,
  input  logic [PA_MAX-1:0] fill_pa_i,
  input  logic [1:0]        fill_gran_i,
  input  logic              fill_global_i,
  input  logic [ID_W-1:0]   fill_asid_i,
  input  logic [ID_W-1:0]   fill_vmid_i,
  input  logic [ATTR_W-1:0] fill_attr_i,
  input  logic              inv_i,
  input  logic [1:0]        inv_kind_i,
  input  logic [ID_W-1:0]   inv_asid_i,
  input  logic [ID_W-1:0]   inv_vmid_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              multi_hit_o,
  output logic [PA_MAX-1:0] pa_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int unsigned VPN_W = VA_W - PG_SHIFT;
  localparam int unsigned PPN_W = PA_MAX - PG_SHIFT;
  localparam int unsigned IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0]  valid_q, valid_d, hit_vec, inv_hit;
  logic [VPN_W-1:0]  vpn_q  [N_ENT];
  logic [PPN_W-1:0]  ppn_q  [N_ENT];
  logic [1:0]        gran_q [N_ENT];
  logic [N_ENT-1:0]  glob_q;
  logic [ID_W-1:0]   asid_q [N_ENT];
  logic [ID_W-1:0]   vmid_q [N_ENT];
  logic [ATTR_W-1:0] attr_q [N_ENT];

  logic [IDX_W-1:0]  hit_idx, vic_idx;
  logic              hit_any, hit_multi;
  logic [PSZ_W-1:0]  eff_bits;
  logic [PA_MAX-1:0] eff_mask, off_mask, pa_next;
  logic              rsp_vld_q, rsp_hit_q, rsp_multi_q;
  logic [PA_MAX-1:0] pa_q;
  logic [ATTR_W-1:0] attr_out_q;
  logic              unused_low;

  assign unused_low = ^{fill_va_i[PG_SHIFT-1:0], fill_pa_i[PG_SHIFT-1:0]};

  // parallel tag compare
  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    vtlb_match #(.VPN_W(VPN_W)) u_match (
      .e_valid_i(valid_q[i]),
      .e_vpn_i  (vpn_q[i]),
      .e_gran_i (gran_q[i]),
      .e_glob_i (glob_q[i]),
      .e_asid_i (asid_q[i]),
      .e_vmid_i (vmid_q[i]),
      .vpn_i    (lk_va_i[VA_W-1:PG_SHIFT]),
      .asid_i   (lk_asid_i),
      .vmid_i   (lk_vmid_i),
      .asid16_i (asid16_i),
      .vmid16_i (vmid16_i),
      .hit_o    (hit_vec[i])
    );

    always_comb begin
      unique case (inv_kind_i)
        INV_ALL:  inv_hit[i] = inv_i;
        INV_ASID: inv_hit[i] = inv_i && !glob_q[i]
                            && id_eq(asid_q[i], inv_asid_i, asid16_i)
                            && id_eq(vmid_q[i], inv_vmid_i, vmid16_i);
        INV_VMID: inv_hit[i] = inv_i && id_eq(vmid_q[i], inv_vmid_i, vmid16_i);
        default:  inv_hit[i] = 1'b0;
      endcase
    end
  end

  vtlb_pick #(.N(N_ENT), .IDX_W(IDX_W)) u_hit_sel (
    .req_i  (hit_vec),
    .idx_o  (hit_idx),
    .any_o  (hit_any),
    .multi_o(hit_multi)
  );

  vtlb_victim #(.N(N_ENT), .IDX_W(IDX_W)) u_victim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_q),
    .fill_i (fill_i),
    .idx_o  (vic_idx)
  );

  // physical address: page base, offset from VA, clamp to width
  always_comb begin
    eff_bits = (pa_bits_i > PSZ_W'(PA_MAX)) ? PSZ_W'(PA_MAX) : pa_bits_i;
    eff_mask = ~({PA_MAX{1'b1}} << eff_bits);
    off_mask = ~({PA_MAX{1'b1}} << (PG_SHIFT + gran_ign(gran_q[hit_idx])));
    pa_next  = (({ppn_q[hit_idx], {PG_SHIFT{1'b0}}} & ~off_mask)
              | (lk_va_i[PA_MAX-1:0] & off_mask)) & eff_mask;
  end

  // invalidate acts on old contents; fill wins for its slot
  always_comb begin
    valid_d = valid_q & ~inv_hit;
    if (fill_i) valid_d[vic_idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      vpn_q[vic_idx]  <= fill_va_i[VA_W-1:PG_SHIFT];
      ppn_q[vic_idx]  <= fill_pa_i[PA_MAX-1:PG_SHIFT];
      gran_q[vic_idx] <= fill_gran_i;
      glob_q[vic_idx] <= fill_global_i;
      asid_q[vic_idx] <= fill_asid_i;
      vmid_q[vic_idx] <= fill_vmid_i;
      attr_q[vic_idx] <= fill_attr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_vld_q   <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_multi_q <= 1'b0;
      pa_q        <= '0;
      attr_out_q  <= '0;
    end else begin
      rsp_vld_q   <= lk_valid_i;
      rsp_hit_q   <= lk_valid_i && hit_any;
      rsp_multi_q <= lk_valid_i && hit_multi;
      pa_q        <= (lk_valid_i && hit_any) ? pa_next : '0;
      attr_out_q  <= (lk_valid_i && hit_any) ? attr_q[hit_idx] : '0;
    end
  end

  assign rsp_valid_o = rsp_vld_q;
  assign hit_o       = rsp_hit_q;
  assign miss_o      = rsp_vld_q && !rsp_hit_q;
  assign multi_hit_o = rsp_multi_q;
  assign pa_o        = pa_q;
  assign attr_o      = attr_out_q;

  assert_fill_lands_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(vic_idx)]);
  assert_inv_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_i && inv_kind_i == INV_ALL && !fill_i) |=> valid_q == '0);
  assert_miss_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && hit_vec == '0) |=> (miss_o && !hit_o));
  assert_multi_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> hit_o);
  assert_pa_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (pa_o & ~$past(eff_mask)) == '0);
  assert_fill_hidden_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && fill_i && hit_vec == '0) |=> miss_o);
endmodule

// File: tb/sim_vtlb_fa.sv
module sim_vtlb_fa;
  localparam int CLK_P = 10;
  localparam int NE    = 48;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        asid16, vmid16;
  logic [6:0]  pa_bits;
  logic        lk_valid;
  logic [47:0] lk_va;
  logic [15:0] lk_asid, lk_vmid;
  logic        fill;
  logic [47:0] fill_va;
  logic [39:0] fill_pa;
  logic [1:0]  fill_gran;
  logic        fill_glob;
  logic [15:0] fill_asid, fill_vmid;
  logic [7:0]  fill_attr;
  logic        inv;
  logic [1:0]  inv_kind;
  logic [15:0] inv_asid, inv_vmid;
  logic        rsp_valid, hit, miss, multi;
  logic [39:0] pa;
  logic [7:0]  attr;

  int checks = 0, fails = 0, rr_m = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  vtlb_fa u0 (
    .clk_i(clk), .rst_ni(rst_ni), .asid16_i(asid16), .vmid16_i(vmid16),
    .pa_bits_i(pa_bits), .lk_valid_i(lk_valid), .lk_va_i(lk_va),
    .lk_asid_i(lk_asid), .lk_vmid_i(lk_vmid), .fill_i(fill),
    .fill_va_i(fill_va), .fill_pa_i(fill_pa), .fill_gran_i(fill_gran),
    .fill_global_i(fill_glob), .fill_asid_i(fill_asid), .fill_vmid_i(fill_vmid),
    .fill_attr_i(fill_attr), .inv_i(inv), .inv_kind_i(inv_kind),
    .inv_asid_i(inv_asid), .inv_vmid_i(inv_vmid), .rsp_valid_o(rsp_valid),
    .hit_o(hit), .miss_o(miss), .multi_hit_o(multi), .pa_o(pa), .attr_o(attr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_fill(input logic [47:0] va, input logic [39:0] p, input logic [1:0] g,
                          input logic gl, input logic [15:0] a, input logic [15:0] v,
                          input logic [7:0] at);
    fill = 1'b1; fill_va = va; fill_pa = p; fill_gran = g;
    fill_glob = gl; fill_asid = a; fill_vmid = v; fill_attr = at;
    rr_m = (rr_m + 1) % NE;
  endtask

  task automatic do_fill(input logic [47:0] va, input logic [39:0] p, input logic [1:0] g,
                         input logic gl, input logic [15:0] a, input logic [15:0] v,
                         input logic [7:0] at);
    set_fill(va, p, g, gl, a, v, at);
    tick();
    fill = 1'b0;
  endtask

  task automatic look(input logic [47:0] va, input logic [15:0] a, input logic [15:0] v);
    lk_valid = 1'b1; lk_va = va; lk_asid = a; lk_vmid = v;
    tick();
    lk_valid = 1'b0;
  endtask

  task automatic do_inv(input logic [1:0] k, input logic [15:0] a, input logic [15:0] v);
    inv = 1'b1; inv_kind = k; inv_asid = a; inv_vmid = v;
    tick();
    inv = 1'b0;
  endtask

  function automatic logic [39:0] xpa(input logic [39:0] base, input logic [47:0] va,
                                      input logic [1:0] g, input int bits);
    int sh;
    logic [39:0] om, r;
    sh = (g == 2'd1) ? 14 : (g == 2'd2) ? 16 : 12;
    om = (40'd1 << sh) - 40'd1;
    r  = (base & ~om) | (va[39:0] & om);
    if (bits < 40) r = r & ((40'd1 << bits) - 40'd1);
    return r;
  endfunction

  task automatic t_reset();
    chk("R9 reset rsp_valid", rsp_valid, 0);
    chk("R9 reset hit", hit, 0);
    chk("R9 reset pa", pa, 0);
    look(48'h0000_1234_5000, 16'd5, 16'd1);
    chk("R9 empty lookup miss", miss, 1);
    chk("R9 empty lookup hit", hit, 0);
  endtask

  task automatic t_basic();
    do_fill(48'h0000_1234_5000, 40'h12_3456_7000, 2'd0, 1'b0, 16'd5, 16'd1, 8'hA5);
    look(48'h0000_1234_5123, 16'd5, 16'd1);
    chk("R9 basic rsp_valid", rsp_valid, 1);
    chk("R9 basic hit", hit, 1);
    chk("R9 basic pa", pa, 40'h12_3456_7123);
    chk("R9 basic attr", attr, 8'hA5);
    chk("R9 single multi", multi, 0);
  endtask

  task automatic t_same_cycle();
    set_fill(48'h0000_2222_2000, 40'h00_2222_0000, 2'd0, 1'b0, 16'd5, 16'd1, 8'h01);
    lk_valid = 1'b1; lk_va = 48'h0000_2222_2010; lk_asid = 16'd5; lk_vmid = 16'd1;
    tick();
    fill = 1'b0; lk_valid = 1'b0;
    chk("R13 same-cycle miss", miss, 1);
    look(48'h0000_2222_2010, 16'd5, 16'd1);
    chk("R13 next-cycle hit", hit, 1);
    chk("R13 next-cycle pa", pa, 40'h00_2222_0010);
  endtask

  task automatic t_asid();
    look(48'h0000_1234_5000, 16'd6, 16'd1);
    chk("R3 other asid miss", miss, 1);
    do_fill(48'h0000_3333_3000, 40'h00_3333_3000, 2'd0, 1'b1, 16'd9, 16'd1, 8'h33);
    look(48'h0000_3333_3004, 16'd77, 16'd1);
    chk("R3 global any asid hit", hit, 1);
    chk("R3 global attr", attr, 8'h33);
  endtask

  task automatic t_vmid();
    look(48'h0000_1234_5000, 16'd5, 16'd2);
    chk("R4 other vmid miss", miss, 1);
    look(48'h0000_3333_3000, 16'd9, 16'd2);
    chk("R4 global other vmid miss", miss, 1);
  endtask

  task automatic t_idw();
    do_fill(48'h0000_4444_4000, 40'h00_4444_4000, 2'd0, 1'b0, 16'h1205, 16'h0101, 8'h44);
    asid16 = 1'b0;
    look(48'h0000_4444_4000, 16'h3405, 16'h0101);
    chk("R5 asid 8-bit hit", hit, 1);
    asid16 = 1'b1;
    look(48'h0000_4444_4000, 16'h3405, 16'h0101);
    chk("R5 asid 16-bit miss", miss, 1);
    vmid16 = 1'b0;
    look(48'h0000_4444_4000, 16'h1205, 16'h0201);
    chk("R6 vmid 8-bit hit", hit, 1);
    vmid16 = 1'b1;
    look(48'h0000_4444_4000, 16'h1205, 16'h0201);
    chk("R6 vmid 16-bit miss", miss, 1);
  endtask

  task automatic t_gran();
    do_fill(48'h0000_5555_0000, 40'hAB_CD00_0000, 2'd2, 1'b0, 16'd5, 16'd1, 8'h55);
    look(48'h0000_5555_F123, 16'd5, 16'd1);
    chk("R7 64K hit", hit, 1);
    chk("R7 64K pa", pa, xpa(40'hAB_CD00_0000, 48'h0000_5555_F123, 2'd2, 40));
    do_fill(48'h0000_6666_4000, 40'h01_2345_8000, 2'd1, 1'b0, 16'd5, 16'd1, 8'h66);
    look(48'h0000_6666_7ABC, 16'd5, 16'd1);
    chk("R7 16K pa", pa, xpa(40'h01_2345_8000, 48'h0000_6666_7ABC, 2'd1, 40));
    look(48'h0000_6666_8000, 16'd5, 16'd1);
    chk("R7 16K next page miss", miss, 1);
  endtask

  task automatic t_paclamp();
    pa_bits = 7'd32;
    look(48'h0000_1234_5123, 16'd5, 16'd1);
    chk("R8 32-bit pa", pa, xpa(40'h12_3456_7000, 48'h0000_1234_5123, 2'd0, 32));
    pa_bits = 7'd20;
    look(48'h0000_1234_5123, 16'd5, 16'd1);
    chk("R8 20-bit pa", pa, 40'h6_7123);
    pa_bits = 7'd63;
    look(48'h0000_5555_F123, 16'd5, 16'd1);
    chk("R8 over-40 request clamps", pa, 40'hAB_CD00_F123);
    pa_bits = 7'd40;
  endtask

  task automatic t_multi();
    do_fill(48'h0000_7777_7000, 40'h00_7777_1000, 2'd0, 1'b0, 16'd5, 16'd1, 8'h11);
    do_fill(48'h0000_7777_7000, 40'h00_7777_2000, 2'd0, 1'b0, 16'd5, 16'd1, 8'h22);
    look(48'h0000_7777_7000, 16'd5, 16'd1);
    chk("R9 multi flag", multi, 1);
    chk("R9 lowest index attr", attr, 8'h11);
    chk("R9 lowest index pa", pa, 40'h00_7777_1000);
  endtask

  task automatic t_inv();
    do_inv(2'd0, 16'd0, 16'd0);
    look(48'h0000_1234_5000, 16'd5, 16'd1);
    chk("R10 inv-all miss", miss, 1);
    look(48'h0000_3333_3000, 16'd9, 16'd1);
    chk("R10 inv-all global miss", miss, 1);
    do_fill(48'h0000_8000_0000, 40'h00_8000_0000, 2'd0, 1'b0, 16'd3, 16'd4, 8'h80);
    do_fill(48'h0000_8000_1000, 40'h00_8000_1000, 2'd0, 1'b1, 16'd3, 16'd4, 8'h81);
    do_fill(48'h0000_8000_2000, 40'h00_8000_2000, 2'd0, 1'b0, 16'd3, 16'd5, 8'h82);
    do_fill(48'h0000_8000_3000, 40'h00_8000_3000, 2'd0, 1'b0, 16'd8, 16'd4, 8'h83);
    do_inv(2'd1, 16'd3, 16'd4);
    look(48'h0000_8000_0000, 16'd3, 16'd4);
    chk("R11 matching entry cleared", miss, 1);
    look(48'h0000_8000_1000, 16'd3, 16'd4);
    chk("R11 global kept", hit, 1);
    look(48'h0000_8000_2000, 16'd3, 16'd5);
    chk("R11 other vmid kept", hit, 1);
    look(48'h0000_8000_3000, 16'd8, 16'd4);
    chk("R11 other asid kept", hit, 1);
    do_inv(2'd2, 16'd0, 16'd4);
    look(48'h0000_8000_1000, 16'd3, 16'd4);
    chk("R12 global same vmid cleared", miss, 1);
    look(48'h0000_8000_3000, 16'd8, 16'd4);
    chk("R12 same vmid cleared", miss, 1);
    look(48'h0000_8000_2000, 16'd3, 16'd5);
    chk("R12 other vmid kept", hit, 1);
    do_inv(2'd3, 16'd3, 16'd5);
    look(48'h0000_8000_2000, 16'd3, 16'd5);
    chk("R10 kind 3 no effect", hit, 1);
  endtask

  task automatic t_fill_inv();
    do_inv(2'd0, 16'd0, 16'd0);
    do_fill(48'h0000_9000_0000, 40'h00_9000_0000, 2'd0, 1'b0, 16'd5, 16'd1, 8'h90);
    inv = 1'b1; inv_kind = 2'd0;
    set_fill(48'h0000_9000_1000, 40'h00_9000_1000, 2'd0, 1'b0, 16'd5, 16'd1, 8'h91);
    tick();
    inv = 1'b0; fill = 1'b0;
    look(48'h0000_9000_0000, 16'd5, 16'd1);
    chk("R14 old entry cleared", miss, 1);
    look(48'h0000_9000_1000, 16'd5, 16'd1);
    chk("R14 filled entry kept", hit, 1);
    chk("R14 filled attr", attr, 8'h91);
  endtask

  task automatic t_full();
    int v;
    do_inv(2'd0, 16'd0, 16'd0);
    for (int k = 0; k < NE; k++)
      do_fill(48'h00A0_0000_0000 | (48'(k) << 12), 40'h50_0000_0000 | (40'(k) << 12),
              2'd0, 1'b0, 16'd5, 16'd1, 8'(k));
    for (int k = 0; k < NE; k++) begin
      look(48'h00A0_0000_0000 | (48'(k) << 12), 16'd5, 16'd1);
      chk("R1 all 48 entries hit", {hit, attr}, {1'b1, 8'(k)});
    end
    v = rr_m;
    do_fill(48'h00B0_0000_0000, 40'h60_0000_0000, 2'd0, 1'b0, 16'd5, 16'd1, 8'hB0);
    look(48'h00A0_0000_0000 | (48'(v) << 12), 16'd5, 16'd1);
    chk("R2 round-robin victim evicted", miss, 1);
    look(48'h00B0_0000_0000, 16'd5, 16'd1);
    chk("R2 new entry hit", hit, 1);
    look(48'h00A0_0000_0000 | (48'((v + 1) % NE) << 12), 16'd5, 16'd1);
    chk("R2 next entry kept", hit, 1);
    do_fill(48'h00B0_0000_1000, 40'h60_0000_1000, 2'd0, 1'b0, 16'd5, 16'd1, 8'hB1);
    look(48'h00A0_0000_0000 | (48'((v + 1) % NE) << 12), 16'd5, 16'd1);
    chk("R2 pointer advanced", miss, 1);
    look(48'h00B0_0000_0000, 16'd5, 16'd1);
    chk("R2 earlier new entry kept", hit, 1);
  endtask

  initial begin
    rst_ni = 1'b0; asid16 = 1'b1; vmid16 = 1'b1; pa_bits = 7'd40;
    lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_vmid = '0;
    fill = 1'b0; fill_va = '0; fill_pa = '0; fill_gran = '0; fill_glob = 1'b0;
    fill_asid = '0; fill_vmid = '0; fill_attr = '0;
    inv = 1'b0; inv_kind = 2'd3; inv_asid = '0; inv_vmid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_cycle();
    t_asid();
    t_vmid();
    t_idw();
    t_gran();
    t_paclamp();
    t_multi();
    t_inv();
    t_fill_inv();
    t_full();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule